// File: doc/BRIEF.md
# Stack-Addressed 80-bit Register File

This block holds eight 80-bit floating-point words and addresses them as a last-in, first-out stack. Operands are not named by fixed register numbers. They are named by their distance from a moving top pointer: the newest value is the top entry, and the one beneath it is the second entry. A caller evaluates expressions in postfix order. It loads operands, then issues operations that take the top one or two entries and leave their result on top.

Each word has three fields: the sign in bit 79, the exponent in bits 78..64 and the fraction in bits 63..0. The arithmetic is a stand-in. It treats the fraction as an unsigned 64-bit integer and copies the sign and exponent from the second entry. Every operation finishes in one clock cycle.

If a ninth value is loaded, the oldest value is lost without any fault. An operation that asks for more entries than the stack holds sets a sticky flag and changes nothing else.

Top module: `rpn_stack_file`

## Requirements
- R1: After synchronous reset, `depth` is 0, `underflow` is 0, `pop_data` is 0 and `top_data` is 0.
- R2: Code 1 (load) with `op_valid` high places `din` on `top_data` in the next cycle. The entries already held shift one position deeper, and `depth` rises by one.
- R3: Loading into a full stack of 8 discards the oldest entry. `depth` stays at 8, and the other seven entries keep their order.
- R4: Code 2 (pop) on a non-empty stack copies the top entry to `pop_data`. The second entry becomes the top, and `depth` falls by one.
- R5: Code 3 replaces the top two entries with one word. Its fraction is (second + top) mod 2^64, its sign and exponent come from the second entry, and `depth` falls by one.
- R6: Code 4 works the same way, but the fraction is (second − top) mod 2^64.
- R7: Code 5 works the same way, but the fraction is the integer quotient of the second fraction divided by the top fraction. A zero top fraction gives an all-ones fraction.
- R8: Code 6 inverts bit 79 of the top entry in place and leaves `depth` unchanged. On an empty stack it sets `underflow` and changes nothing else.
- R9: A pop on an empty stack, or code 3, 4 or 5 with fewer than two entries, sets `underflow` and leaves the stack, `depth` and `pop_data` unchanged. `underflow` then stays at 1 until reset.
- R10: Code 0, code 7, or any cycle with `op_valid` low leaves every output unchanged.
- R11: `pop_data` changes only on a successful pop. Loads and arithmetic operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies `op_code` for this cycle |
| op_code | input | 3 | Operation code (0 idle, 1 load, 2 pop, 3 add, 4 subtract, 5 divide, 6 negate) |
| din | input | 80 | Value to load |
| pop_data | output | 80 | Last value removed by a pop |
| top_data | output | 80 | Current top entry |
| depth | output | 4 | Number of live entries, 0 to 8 |
| underflow | output | 1 | Sticky flag for an operation on too few entries |

## Verification
Short directed sequences check each arithmetic code with operands whose results differ by order. For example, subtracting and dividing with unequal operands shows whether the second and top entries were swapped. A zero divisor exercises the all-ones case.

A run of ten loads followed by eight pops tells a correct discard of the oldest entry apart from a wrap that corrupts live entries. Pops and operations on an empty stack or a one-entry stack confirm that underflow changes nothing.

A long mixed stream of random codes, valid strobes and data is then compared against a queue-based model on every cycle. It reaches combinations that the directed steps do not, such as a negate straight after an overflow.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int unsigned FRAC_W  = 64;
    localparam int unsigned EXP_W   = 15;
    localparam int unsigned ENTRY_W = FRAC_W + EXP_W + 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [2:0] {
        OPC_IDLE = 3'd0,
        OPC_LOAD = 3'd1,
        OPC_DROP = 3'd2,
        OPC_SUM  = 3'd3,
        OPC_DIFF = 3'd4,
        OPC_QUOT = 3'd5,
        OPC_FLIP = 3'd6
    } opc_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
(
    input  logic [2:0] opc,
    input  fp_word_t   tos,
    input  fp_word_t   nos,
    output fp_word_t   bin_res,
    output fp_word_t   neg_res
);

    logic tos_zero;

    assign tos_zero = (tos.frac == '0);

    // Binary result: sign and exponent carried from the second entry.
    always_comb begin
        bin_res = nos;
        case (opc)
            OPC_SUM:  bin_res.frac = nos.frac + tos.frac;
            OPC_DIFF: bin_res.frac = nos.frac - tos.frac;
            OPC_QUOT: bin_res.frac = tos_zero ? {FRAC_W{1'b1}} : (nos.frac / tos.frac);
            default:  bin_res.frac = nos.frac;
        endcase
    end

    // Unary result: only the sign is inverted.
    always_comb begin
        neg_res      = tos;
        neg_res.sign = ~tos.sign;
    end

endmodule

// File: rtl/stk_bank.sv
module stk_bank
    import stk_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  fp_word_t         wr_val,
    input  logic [PTR_W-1:0] rd_idx_a,
    input  logic [PTR_W-1:0] rd_idx_b,
    output fp_word_t         rd_a,
    output fp_word_t         rd_b
);

    fp_word_t mem_q [DEPTH];
    fp_word_t mem_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && (wr_idx == PTR_W'(g))) begin
                mem_d[g] = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rd_a = mem_q[rd_idx_a];
    assign rd_b = mem_q[rd_idx_b];

    // R2: a written value is readable at the written slot in the next cycle
    bank_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !$isunknown(wr_idx)) |=> (mem_q[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/stk_fill.sv
module stk_fill #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grow,
    input  logic             shrink,
    output logic [CNT_W-1:0] level
);

    logic [CNT_W-1:0] level_d, level_q;

    always_comb begin
        level_d = level_q;
        if (grow && !shrink) begin
            if (level_q != CNT_W'(DEPTH)) begin
                level_d = level_q + 1'b1;
            end
        end else if (shrink && !grow) begin
            if (level_q != '0) begin
                level_d = level_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            level_q <= level_d;
        end
    end

    assign level = level_q;

    // R3
    fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (level_q == CNT_W'(DEPTH) && grow && !shrink) |=> (level_q == CNT_W'(DEPTH)));

    // R3
    fill_range_chk: assert property (@(posedge clk) disable iff (rst)
        level_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/rpn_stack_file.sv
module rpn_stack_file
    import stk_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [2:0]         op_code,
    input  logic [ENTRY_W-1:0] din,
    output logic [ENTRY_W-1:0] pop_data,
    output logic [ENTRY_W-1:0] top_data,
    output logic [CNT_W-1:0]   depth,
    output logic               underflow
);

    typedef struct packed {
        logic [PTR_W-1:0]   ptr;
        logic               uflow;
        logic [ENTRY_W-1:0] popped;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    fp_word_t         wr_val;
    logic [PTR_W-1:0] ptr_up, ptr_dn;
    fp_word_t         tos, nos, bin_res, neg_res;
    logic             grow, shrink;
    logic [CNT_W-1:0] level;
    logic             has_one, has_two;

    assign ptr_up  = ctl_q.ptr + 1'b1;
    assign ptr_dn  = ctl_q.ptr - 1'b1;
    assign has_one = (level != '0);
    assign has_two = (level >= CNT_W'(2));

    stk_bank #(.DEPTH(DEPTH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .rd_idx_a (ctl_q.ptr),
        .rd_idx_b (ptr_up),
        .rd_a     (tos),
        .rd_b     (nos)
    );

    stk_alu u_alu (
        .opc     (op_code),
        .tos     (tos),
        .nos     (nos),
        .bin_res (bin_res),
        .neg_res (neg_res)
    );

    stk_fill #(.DEPTH(DEPTH)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .grow   (grow),
        .shrink (shrink),
        .level  (level)
    );

    always_comb begin
        ctl_d  = ctl_q;
        wr_en  = 1'b0;
        wr_idx = ctl_q.ptr;
        wr_val = tos;
        grow   = 1'b0;
        shrink = 1'b0;
        if (op_valid) begin
            case (op_code)
                OPC_LOAD: begin
                    wr_en     = 1'b1;
                    wr_idx    = ptr_dn;
                    wr_val    = fp_word_t'(din);
                    ctl_d.ptr = ptr_dn;
                    grow      = 1'b1;
                end
                OPC_DROP: begin
                    if (!has_one) begin
                        ctl_d.uflow = 1'b1;
                    end else begin
                        ctl_d.popped = tos;
                        ctl_d.ptr    = ptr_up;
                        shrink       = 1'b1;
                    end
                end
                OPC_SUM, OPC_DIFF, OPC_QUOT: begin
                    if (!has_two) begin
                        ctl_d.uflow = 1'b1;
                    end else begin
                        wr_en     = 1'b1;
                        wr_idx    = ptr_up;
                        wr_val    = bin_res;
                        ctl_d.ptr = ptr_up;
                        shrink    = 1'b1;
                    end
                end
                OPC_FLIP: begin
                    if (!has_one) begin
                        ctl_d.uflow = 1'b1;
                    end else begin
                        wr_en  = 1'b1;
                        wr_idx = ctl_q.ptr;
                        wr_val = neg_res;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pop_data  = ctl_q.popped;
    assign top_data  = tos;
    assign depth     = level;
    assign underflow = ctl_q.uflow;

    // R2
    load_top_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OPC_LOAD) |=> (top_data == $past(din)));

    // R4
    pop_value_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OPC_DROP && depth != '0) |=> (pop_data == $past(top_data)));

    // R8
    flip_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OPC_FLIP && depth != '0)
        |=> (top_data == {~$past(top_data[ENTRY_W-1]), $past(top_data[ENTRY_W-2:0])}));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OPC_DROP && depth == '0)
        |=> (underflow && depth == $past(depth) && $stable(pop_data)));

    // R9
    uflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid) |=> ($stable(top_data) && $stable(depth) && $stable(pop_data)));

    // R11
    pop_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code != OPC_DROP) |=> $stable(pop_data));

endmodule

// File: tb/rpn_stack_file_test.sv
module rpn_stack_file_test;

    localparam int DEPTH = 8;
    localparam logic [2:0] C_IDLE = 3'd0, C_LOAD = 3'd1, C_DROP = 3'd2, C_SUM = 3'd3,
                           C_DIFF = 3'd4, C_QUOT = 3'd5, C_FLIP = 3'd6, C_SPARE = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [79:0] din = '0;
    logic [79:0] pop_data, top_data;
    logic [3:0]  depth;
    logic        underflow;

    rpn_stack_file uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .din(din),
        .pop_data(pop_data), .top_data(top_data), .depth(depth), .underflow(underflow)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    logic [79:0] mdl[$];
    logic        m_uflow = 1'b0;
    logic [79:0] m_pop = '0;

    task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(string req);
        chk(req, "depth", 80'(depth), 80'(mdl.size()));
        chk(req, "underflow", 80'(underflow), 80'(m_uflow));
        chk(req, "pop_data", pop_data, m_pop);
        if (mdl.size() > 0) chk(req, "top_data", top_data, mdl[0]);
    endtask

    function automatic logic [79:0] arith(logic [2:0] op, logic [79:0] t, logic [79:0] n);
        logic [79:0] r;
        r = n;
        case (op)
            C_SUM:  r[63:0] = n[63:0] + t[63:0];
            C_DIFF: r[63:0] = n[63:0] - t[63:0];
            C_QUOT: r[63:0] = (t[63:0] == 64'd0) ? {64{1'b1}} : n[63:0] / t[63:0];
            default: r = n;
        endcase
        return r;
    endfunction

    task automatic model(logic v, logic [2:0] op, logic [79:0] d);
        logic [79:0] t, n;
        if (!v) return;
        case (op)
            C_LOAD: begin
                mdl.push_front(d);
                if (mdl.size() > DEPTH) void'(mdl.pop_back());
            end
            C_DROP: begin
                if (mdl.size() == 0) m_uflow = 1'b1;
                else m_pop = mdl.pop_front();
            end
            C_SUM, C_DIFF, C_QUOT: begin
                if (mdl.size() < 2) m_uflow = 1'b1;
                else begin
                    t = mdl.pop_front();
                    n = mdl.pop_front();
                    mdl.push_front(arith(op, t, n));
                end
            end
            C_FLIP: begin
                if (mdl.size() == 0) m_uflow = 1'b1;
                else mdl[0][79] = ~mdl[0][79];
            end
            default: begin
            end
        endcase
    endtask

    task automatic step(logic v, logic [2:0] op, logic [79:0] d, string req);
        @(negedge clk);
        op_valid = v;
        op_code  = op;
        din      = d;
        @(posedge clk);
        model(v, op, d);
        #1;
        chk_state(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        mdl.delete();
        m_uflow = 1'b0;
        m_pop = '0;
        // R1: reset state at the ports
        chk("R1", "depth", 80'(depth), 80'd0);
        chk("R1", "underflow", 80'(underflow), 80'd0);
        chk("R1", "pop_data", pop_data, 80'd0);
        chk("R1", "top_data", top_data, 80'd0);
        rst = 1'b0;
    endtask

    function automatic logic [79:0] mk(logic s, logic [14:0] e, logic [63:0] f);
        return {s, e, f};
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog run did not complete");
        summary();
    end

    initial begin
        logic [2:0]  rop;
        logic [79:0] rd;
        do_reset();

        // R2: loads
        step(1'b1, C_LOAD, mk(1'b0, 15'h3fff, 64'd100), "R2");
        step(1'b1, C_LOAD, mk(1'b1, 15'h1234, 64'd30), "R2");
        step(1'b1, C_LOAD, mk(1'b0, 15'h0001, 64'd7), "R2");
        // R10: idle code, spare code, strobe low
        step(1'b1, C_IDLE, '1, "R10");
        step(1'b1, C_SPARE, '1, "R10");
        step(1'b0, C_LOAD, '1, "R10");
        step(1'b0, C_DROP, '0, "R10");
        // R5: 30 + 7 under second entry's sign/exponent
        step(1'b1, C_SUM, '0, "R5");
        chk("R5", "sum word", top_data, mk(1'b1, 15'h1234, 64'd37));
        // R6: 100 - 37, ordering visible
        step(1'b1, C_DIFF, '0, "R6");
        chk("R6", "diff word", top_data, mk(1'b0, 15'h3fff, 64'd63));
        // R6: wrap below zero
        step(1'b1, C_LOAD, mk(1'b0, 15'h0, 64'd64), "R2");
        step(1'b1, C_DIFF, '0, "R6");
        chk("R6", "diff wrap", top_data, mk(1'b0, 15'h3fff, {64{1'b1}}));
        // R7: quotient and zero divisor
        step(1'b1, C_LOAD, mk(1'b0, 15'h2, 64'd1000), "R2");
        step(1'b1, C_LOAD, mk(1'b1, 15'h3, 64'd7), "R2");
        step(1'b1, C_QUOT, '0, "R7");
        chk("R7", "quotient", top_data, mk(1'b0, 15'h2, 64'd142));
        step(1'b1, C_LOAD, mk(1'b0, 15'h0, 64'd0), "R2");
        step(1'b1, C_QUOT, '0, "R7");
        chk("R7", "zero divisor", top_data[63:0], {16'd0, {64{1'b1}}});
        // R8: negate in place
        step(1'b1, C_FLIP, '0, "R8");
        step(1'b1, C_FLIP, '0, "R8");
        // R11: pop_data kept through loads and arithmetic
        step(1'b1, C_DROP, '0, "R4");
        step(1'b1, C_LOAD, mk(1'b0, 15'h5, 64'd9), "R11");
        step(1'b1, C_SUM, '0, "R11");
        // R4: drain
        while (mdl.size() > 0) step(1'b1, C_DROP, '0, "R4");
        // R9: pop on empty, binary with one entry
        step(1'b1, C_DROP, '0, "R9");
        step(1'b1, C_LOAD, mk(1'b0, 15'h7, 64'd5), "R2");
        step(1'b1, C_QUOT, '0, "R9");
        step(1'b1, C_SUM, '0, "R9");
        step(1'b1, C_DROP, '0, "R4");
        step(1'b1, C_DROP, '0, "R9");
        step(1'b1, C_IDLE, '0, "R9");

        // R8: negate on empty after fresh reset
        do_reset();
        step(1'b1, C_FLIP, '0, "R8");

        // R3: overflow discards oldest
        do_reset();
        for (int i = 1; i <= 10; i++) step(1'b1, C_LOAD, mk(1'b0, 15'(i), 64'(i * 11)), "R3");
        chk("R3", "depth full", 80'(depth), 80'd8);
        for (int i = 0; i < 8; i++) step(1'b1, C_DROP, '0, "R3");
        chk("R3", "oldest surviving", pop_data, mk(1'b0, 15'd3, 64'd33));
        step(1'b1, C_DROP, '0, "R9");

        // mixed stream compared every cycle
        do_reset();
        for (int k = 0; k < 3000; k++) begin
            rop = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) rop = C_LOAD;
            rd  = {16'($urandom), 32'($urandom), 32'($urandom_range(0, 40))};
            step(($urandom_range(0, 9) != 0), rop, rd, "R10");
        end

        summary();
    end

endmodule